// File: doc/BRIEF.md
# Sectored Direct-Mapped Cache Controller

This controller manages a direct-mapped cache whose lines are split into word-sized sectors. Each line holds one address tag. Every sector in the line has its own valid flag and its own dirty flag. A line can therefore be resident with only some of its sectors present. A tag match on a sector that is not present counts as a miss for that sector only. The controller then fetches the missing word and leaves the tag and the other sectors as they are.

The CPU side uses a word (sector) address, a byte-enable mask and a request/done handshake. The memory side moves one word per transaction, with a request that is held until an acknowledge arrives.

On a read miss, the controller fetches the requested word first and returns it to the CPU. It then fills the other missing sectors of an aligned group of `FILL_GROUP` sectors. A write that covers all bytes of a sector needs no memory read. A partial write to a missing sector fetches that sector first and then merges the written bytes. A tag mismatch evicts the line: each dirty sector is written back, and only then is the new tag installed with every sector marked invalid.

Top module: `sector_cache_ctrl`

## Requirements
- R1: After reset, `cpu_ready` is 1 and `mem_req` and `cpu_done` are 0. No line holds a tag, so the first access to any line misses.
- R2: A read whose tag matches and whose sector is valid returns the stored word on `cpu_rdata` with no memory transaction.
- R3: A read whose tag matches but whose sector is invalid fetches that sector's word address without writing back anything. Sectors already valid in the line keep hitting afterwards.
- R4: A write with `cpu_be` = 4'b1111 to an invalid sector of a matching line issues no memory read. The sector becomes valid and dirty, and later reads return the written word.
- R5: A write with any other byte mask to an invalid sector first reads that sector from memory. It then merges the enabled bytes (bit b of `cpu_be` selects bits 8b+7..8b) and marks the sector dirty.
- R6: A tag mismatch writes back exactly the dirty sectors of the old line, in ascending sector order, to the word addresses {old tag, index, sector}. Clean sectors are not written back. Afterwards no sector of the old line is valid.
- R7: A write hit merges the enabled bytes into the stored word, marks the sector dirty and makes no memory transaction.
- R8: On a read miss, the first memory read is the requested word, and `cpu_done` rises when that read completes. The controller then reads the still-invalid sectors of the aligned group of `FILL_GROUP` sectors containing it, from the lowest sector upward, while `cpu_ready` stays 0.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold steady.
- R10: `cpu_done` is a single-cycle pulse. `cpu_ready` is 1 only when no access is in progress, and then no memory request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_waddr | input | ADDR_W-2 | Word address {tag, index, sector} |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for a write |
| cpu_ready | output | 1 | Controller is idle and can take a request |
| cpu_done | output | 1 | One-cycle pulse when the access completes |
| cpu_rdata | output | 32 | Word read, or the merged word after a write, valid with `cpu_done` |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 for a write-back, 0 for a fetch |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Fetched data, valid with `mem_ack` |
| mem_ack | input | 1 | Completes the current memory transaction |

## Verification
The assertions check, on every cycle, the behaviour that is visible on the ports:
- The memory request keeps its address and data steady until it is acknowledged.
- `cpu_done` is a single-cycle pulse.
- An idle controller never requests memory.
- The controller is idle straight after reset.

Only the bench's scenarios can show that the sector state is right, because that state is inside the controller. The scenarios do this by counting and logging memory transactions and by comparing returned data with a reference model. This covers:
- tag hits on missing sectors;
- full and partial writes to missing sectors;
- write-back of only the dirty sectors;
- ordering of the requested word ahead of the group fill.

A pseudo-random sweep over a few tags per line then checks that reads stay coherent across repeated evictions.

// File: rtl/sector_cache_ctrl.sv
module sector_cache_ctrl #(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 64,
  parameter int SECT_BYTES = 4,
  parameter int LINES      = 4,
  parameter int FILL_GROUP = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpu_req,
  input  logic                     cpu_we,
  input  logic [ADDR_W-3:0]        cpu_waddr,
  input  logic [SECT_BYTES*8-1:0]  cpu_wdata,
  input  logic [SECT_BYTES-1:0]    cpu_be,
  output logic                     cpu_ready,
  output logic                     cpu_done,
  output logic [SECT_BYTES*8-1:0]  cpu_rdata,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-3:0]        mem_addr,
  output logic [SECT_BYTES*8-1:0]  mem_wdata,
  input  logic [SECT_BYTES*8-1:0]  mem_rdata,
  input  logic                     mem_ack
);
  localparam int NB    = SECT_BYTES;
  localparam int DW    = NB * 8;
  localparam int SECTS = LINE_BYTES / SECT_BYTES;
  localparam int SEC_W = $clog2(SECTS);
  localparam int IDX_W = $clog2(LINES);
  localparam int WA_W  = ADDR_W - 2;
  localparam int TAG_W = WA_W - SEC_W - IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_EVICT, S_FETCH, S_FILL} st_t;

  st_t               state;
  logic              r_we;
  logic [WA_W-1:0]   r_wa;
  logic [DW-1:0]     r_wdata;
  logic [NB-1:0]     r_be;

  logic [DW-1:0]     store_q [LINES][SECTS];
  logic [SECTS-1:0]  vld_q   [LINES];
  logic [SECTS-1:0]  drt_q   [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [LINES-1:0]  own_q;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [NB-1:0] be);
    merge = old_w;
    for (int b = 0; b < NB; b++)
      if (be[b]) merge[b*8 +: 8] = new_w[b*8 +: 8];
  endfunction

  function automatic logic [SEC_W-1:0] lowest(input logic [SECTS-1:0] v);
    lowest = '0;
    for (int i = SECTS-1; i >= 0; i--)
      if (v[i]) lowest = SEC_W'(i);
  endfunction

  logic [SEC_W-1:0] r_sec;
  logic [IDX_W-1:0] r_idx;
  logic [TAG_W-1:0] r_tag;
  assign r_sec = r_wa[SEC_W-1:0];
  assign r_idx = r_wa[SEC_W +: IDX_W];
  assign r_tag = r_wa[WA_W-1 -: TAG_W];

  logic [SECTS-1:0] cur_vld, cur_drt, grp_mask, fill_need;
  logic             tag_match, sec_hit, full_wr, dirty_any;
  logic [SEC_W-1:0] dirty_ptr, fill_ptr;
  logic [DW-1:0]    hit_word, hit_merged, fetch_merged;

  assign cur_vld   = vld_q[r_idx];
  assign cur_drt   = drt_q[r_idx];
  assign tag_match = own_q[r_idx] && (tag_q[r_idx] == r_tag);
  assign sec_hit   = cur_vld[r_sec];
  assign full_wr   = &r_be;
  assign dirty_any = |cur_drt;
  assign dirty_ptr = lowest(cur_drt);
  assign hit_word  = store_q[r_idx][r_sec];
  assign hit_merged   = merge(hit_word, r_wdata, r_be);
  assign fetch_merged = r_we ? merge(mem_rdata, r_wdata, r_be) : mem_rdata;

  always_comb
    for (int s = 0; s < SECTS; s++)
      grp_mask[s] = (s / FILL_GROUP) == (int'(r_sec) / FILL_GROUP);

  assign fill_need = grp_mask & ~cur_vld;
  assign fill_ptr  = lowest(fill_need);

  assign cpu_ready = (state == S_IDLE);
  assign mem_req   = (state == S_EVICT && dirty_any) || (state == S_FETCH) ||
                     (state == S_FILL && |fill_need);
  assign mem_we    = (state == S_EVICT) && dirty_any;
  assign mem_addr  = (state == S_EVICT) ? {tag_q[r_idx], r_idx, dirty_ptr} :
                     (state == S_FILL)  ? {r_tag, r_idx, fill_ptr} : r_wa;
  assign mem_wdata = store_q[r_idx][dirty_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      r_we      <= 1'b0;
      r_wa      <= '0;
      r_wdata   <= '0;
      r_be      <= '0;
      own_q     <= '0;
      for (int l = 0; l < LINES; l++) begin
        vld_q[l] <= '0;
        drt_q[l] <= '0;
        tag_q[l] <= '0;
      end
    end else begin
      cpu_done <= 1'b0;
      case (state)
        S_IDLE:
          if (cpu_req) begin
            r_we    <= cpu_we;
            r_wa    <= cpu_waddr;
            r_wdata <= cpu_wdata;
            r_be    <= cpu_be;
            state   <= S_CHECK;
          end
        S_CHECK:
          if (!tag_match) begin
            state <= S_EVICT;
          end else if (sec_hit) begin
            cpu_done  <= 1'b1;
            cpu_rdata <= r_we ? hit_merged : hit_word;
            if (r_we) drt_q[r_idx][r_sec] <= 1'b1;
            state <= S_IDLE;
          end else if (r_we && full_wr) begin
            vld_q[r_idx][r_sec] <= 1'b1;
            drt_q[r_idx][r_sec] <= 1'b1;
            cpu_done  <= 1'b1;
            cpu_rdata <= r_wdata;
            state <= S_IDLE;
          end else begin
            state <= S_FETCH;
          end
        S_EVICT:
          if (dirty_any) begin
            if (mem_ack) drt_q[r_idx][dirty_ptr] <= 1'b0;
          end else begin
            vld_q[r_idx] <= '0;
            tag_q[r_idx] <= r_tag;
            own_q[r_idx] <= 1'b1;
            state <= S_CHECK;
          end
        S_FETCH:
          if (mem_ack) begin
            vld_q[r_idx][r_sec] <= 1'b1;
            if (r_we) drt_q[r_idx][r_sec] <= 1'b1;
            cpu_done  <= 1'b1;
            cpu_rdata <= fetch_merged;
            state <= (FILL_GROUP > 1) ? S_FILL : S_IDLE;
          end
        S_FILL:
          if (!(|fill_need)) state <= S_IDLE;
          else if (mem_ack) vld_q[r_idx][fill_ptr] <= 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_CHECK && tag_match && r_we && (sec_hit || full_wr))
      store_q[r_idx][r_sec] <= sec_hit ? hit_merged : r_wdata;
    else if (state == S_FETCH && mem_ack)
      store_q[r_idx][r_sec] <= fetch_merged;
    else if (state == S_FILL && |fill_need && mem_ack)
      store_q[r_idx][fill_ptr] <= mem_rdata;
  end
endmodule

// File: rtl/sector_cache_ctrl_chk.sv
module sector_cache_ctrl_chk #(
  parameter int WA_W = 10,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            cpu_ready,
  input logic            cpu_done,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [WA_W-1:0] mem_addr,
  input logic [DW-1:0]   mem_wdata
);
  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> cpu_ready && !mem_req && !cpu_done);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  // R10
  idle_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !mem_req);

  // R6
  wb_is_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);
endmodule

bind sector_cache_ctrl sector_cache_ctrl_chk #(.WA_W(WA_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/tb_sector_cache_ctrl.sv
`timescale 1ns/1ps
module tb_sector_cache_ctrl;
  logic        clk = 0, rst = 1;
  logic        cpu_req = 0, cpu_we = 0;
  logic [9:0]  cpu_waddr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic        cpu_ready, cpu_done;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 0;

  sector_cache_ctrl dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_waddr(cpu_waddr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always #10 clk = ~clk;

  logic [31:0] mem     [0:1023];
  logic [31:0] exp_mem [0:1023];
  logic [9:0]  rlog [0:63];
  logic [9:0]  wlog [0:63];
  int rd_cnt = 0, wr_cnt = 0, wait_cnt = 0;
  int tests = 0, fails = 0;
  bit r9_bad = 0, finished = 0;
  logic [9:0] pend_addr;
  logic       pend_we;

  int rd0, wr0, rd_at_done;
  logic [31:0] got;
  logic ready_at_done, done_after;

  function automatic logic [9:0] wa(input int tag, input int idx, input int sec);
    return {tag[3:0], idx[1:0], sec[3:0]};
  endfunction

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    mrg = o;
    for (int b = 0; b < 4; b++) if (be[b]) mrg[b*8 +: 8] = n[b*8 +: 8];
  endfunction

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 0;
      wait_cnt = 0;
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        pend_addr = mem_addr;
        pend_we = mem_we;
      end else if (pend_addr != mem_addr || pend_we != mem_we) r9_bad = 1;
      if (wait_cnt == 2) begin
        mem_ack = 1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wlog[wr_cnt % 64] = mem_addr;
          wr_cnt++;
        end else begin
          mem_rdata = mem[mem_addr];
          rlog[rd_cnt % 64] = mem_addr;
          rd_cnt++;
        end
      end else wait_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [9:0] w, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    cpu_req = 1; cpu_we = we; cpu_waddr = w; cpu_wdata = d; cpu_be = be;
    @(negedge clk);
    cpu_req = 0;
    while (!cpu_done) @(negedge clk);
    got = cpu_rdata;
    rd_at_done = rd_cnt;
    ready_at_done = cpu_ready;
    @(negedge clk);
    done_after = cpu_done;
    while (!cpu_ready) @(negedge clk);
    if (we) exp_mem[w] = mrg(exp_mem[w], d, be);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cpu_ready == 1, "R1 ready", 32'(cpu_ready), 1);
    chk(mem_req == 0, "R1 mem_req", 32'(mem_req), 0);
    chk(cpu_done == 0, "R1 done", 32'(cpu_done), 0);

    access(0, wa(1,0,5), 0, 0);
    chk(got == exp_mem[wa(1,0,5)], "R1 first read data", got, exp_mem[wa(1,0,5)]);
    chk(rd_cnt - rd0 == 2, "R8 group reads", rd_cnt - rd0, 2);
    chk(rlog[rd0 % 64] == wa(1,0,5), "R8 critical first", 32'(rlog[rd0 % 64]), 32'(wa(1,0,5)));
    chk(rlog[(rd0+1) % 64] == wa(1,0,4), "R8 group fill addr", 32'(rlog[(rd0+1) % 64]), 32'(wa(1,0,4)));
    chk(rd_at_done - rd0 == 1, "R8 done before fill", rd_at_done - rd0, 1);
    chk(ready_at_done == 0, "R10 busy during fill", 32'(ready_at_done), 0);
    chk(done_after == 0, "R10 done pulse", 32'(done_after), 0);

    access(0, wa(1,0,4), 0, 0);
    chk(rd_cnt - rd0 == 0, "R2 no mem on hit", rd_cnt - rd0, 0);
    chk(got == exp_mem[wa(1,0,4)], "R2 hit data", got, exp_mem[wa(1,0,4)]);

    access(0, wa(1,0,9), 0, 0);
    chk(rd_cnt - rd0 == 2, "R3 sector miss reads", rd_cnt - rd0, 2);
    chk(rlog[rd0 % 64] == wa(1,0,9), "R3 sector addr", 32'(rlog[rd0 % 64]), 32'(wa(1,0,9)));
    chk(wr_cnt - wr0 == 0, "R3 no writeback", wr_cnt - wr0, 0);
    access(0, wa(1,0,5), 0, 0);
    chk(rd_cnt - rd0 == 0, "R3 tag kept", rd_cnt - rd0, 0);

    for (int s = 0; s < 16; s++) begin
      access(1, wa(2,1,s), 32'hC0DE0000 + s * 32'h111, 4'hF);
      chk(rd_cnt - rd0 == 0, "R4 full write no read", rd_cnt - rd0, 0);
    end
    for (int s = 0; s < 16; s++) begin
      access(0, wa(2,1,s), 0, 0);
      chk(rd_cnt - rd0 == 0 && got == exp_mem[wa(2,1,s)], "R4 readback", got, exp_mem[wa(2,1,s)]);
    end

    access(1, wa(3,2,6), 32'h11223344, 4'b0101);
    chk(rd_cnt - rd0 == 2, "R5 fetch before merge", rd_cnt - rd0, 2);
    chk(rlog[rd0 % 64] == wa(3,2,6), "R5 fetch addr", 32'(rlog[rd0 % 64]), 32'(wa(3,2,6)));
    access(0, wa(3,2,6), 0, 0);
    chk(got == exp_mem[wa(3,2,6)], "R5 merged data", got, exp_mem[wa(3,2,6)]);

    access(1, wa(1,0,5), 32'hDEADBEEF, 4'b1000);
    chk(rd_cnt - rd0 == 0 && wr_cnt - wr0 == 0, "R7 write hit no mem", rd_cnt - rd0 + wr_cnt - wr0, 0);
    access(0, wa(1,0,5), 0, 0);
    chk(got == exp_mem[wa(1,0,5)], "R7 merged hit", got, exp_mem[wa(1,0,5)]);

    access(0, wa(5,1,0), 0, 0);
    chk(wr_cnt - wr0 == 16, "R6 dirty writebacks", wr_cnt - wr0, 16);
    for (int s = 0; s < 16; s++) begin
      chk(wlog[(wr0 + s) % 64] == wa(2,1,s), "R6 writeback order", 32'(wlog[(wr0 + s) % 64]), 32'(wa(2,1,s)));
      chk(mem[wa(2,1,s)] == exp_mem[wa(2,1,s)], "R6 writeback data", mem[wa(2,1,s)], exp_mem[wa(2,1,s)]);
    end
    chk(got == exp_mem[wa(5,1,0)], "R6 new line data", got, exp_mem[wa(5,1,0)]);
    access(0, wa(5,1,3), 0, 0);
    chk(rd_cnt - rd0 == 2, "R6 old sectors invalid", rd_cnt - rd0, 2);

    access(0, wa(7,0,2), 0, 0);
    chk(wr_cnt - wr0 == 1, "R6 only dirty written", wr_cnt - wr0, 1);
    chk(wlog[wr0 % 64] == wa(1,0,5), "R6 dirty addr", 32'(wlog[wr0 % 64]), 32'(wa(1,0,5)));
    chk(mem[wa(1,0,5)] == exp_mem[wa(1,0,5)], "R6 dirty value", mem[wa(1,0,5)], exp_mem[wa(1,0,5)]);

    access(0, wa(6,3,0), 0, 0);
    access(0, wa(8,3,0), 0, 0);
    chk(wr_cnt - wr0 == 0, "R6 clean eviction", wr_cnt - wr0, 0);
    chk(rd_cnt - rd0 == 2, "R3 refetch after evict", rd_cnt - rd0, 2);

    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      logic [9:0] w;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      w = {2'b00, lf[1:0], lf[3:2], lf[7:4]};
      if (lf[8]) access(1, w, {lf, lf ^ 16'h5A3C}, lf[12:9]);
      else begin
        access(0, w, 0, 0);
        chk(got == exp_mem[w], "R2 sweep coherence", got, exp_mem[w]);
      end
    end

    chk(r9_bad == 0, "R9 request held", 32'(r9_bad), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule